// File: doc/BRIEF.md
# Accumulator Register File with Saturating and Exact Access Views

The block holds four wide accumulators for a signal-processing datapath. Each accumulator is 36 bits wide and is made of three parts. Bits 35:32 are a 4-bit guard extension, bits 31:16 are the high word and bits 15:0 are the low word. Both the datapath and register moves reach the file through one write port and one read port. Each port carries an accumulator select, a view code and a portion code.

The view decides how the same stored bits are seen:

- **Full view.** A read passes through a limiter. When the guard bits no longer agree with bit 31, the read returns the largest positive or most negative 32-bit value and raises a limit flag.
- **Long view.** The low 32 bits move with no limiting.
- **Portion view.** One of the three parts is addressed alone. This view never limits, so a context can be saved and restored bit-exactly.

On the two upper accumulators, only the high word can be addressed as a portion. An attempt to reach their extension or low word is reported as illegal and changes nothing.

Reads are combinational from the stored state. A write takes effect at the rising clock edge. A read that targets the accumulator being written in the same cycle therefore sees the value from before the write.

Top module: `acc_file`

## Requirements
- R1: After reset every accumulator holds zero, and a long-view read of any accumulator returns 0.
- R2: A full-view write with portion code other than 1 loads all 36 bits of `wr_data`. A full-view read of a value whose bits 35:32 all equal bit 31 returns it unchanged, with `rd_limit` low.
- R3: A full-view read of a value whose bits 35:32 are not all equal to bit 31 returns 0x0_7FFF_FFFF when bit 35 is 0, or 0xF_8000_0000 when bit 35 is 1. `rd_limit` is high in that same cycle and only for full-view reads.
- R4: A long-view read (view code 1) returns bits 31:0 of the accumulator sign-extended from bit 31 into bits 35:32. It never limits and never raises `rd_limit`.
- R5: A long-view write stores `wr_data[31:0]` in bits 31:0 and fills bits 35:32 with copies of `wr_data[31]`.
- R6: A portion-view read (view code 2) returns the selected part zero-extended in the low bits of `rd_data`, with no limiting. The portion codes are: 0 for bits 35:32, 1 for bits 31:16, 2 for bits 15:0.
- R7: A portion-view write replaces only the selected part, taken from the low bits of `wr_data`, and leaves the other two parts unchanged.
- R8: A full-view write with portion code 1 is a word move. Bits 31:16 take `wr_data[15:0]`, bits 35:32 take copies of `wr_data[15]`, and bits 15:0 become zero.
- R9: The following accesses are illegal:
  - a portion access to part 0 or part 2 of accumulator 2 or 3;
  - portion code 3 in portion view;
  - view code 3.
  An illegal write raises `wr_illegal` and changes no accumulator. An illegal read raises `rd_illegal` and returns 0. Part 1 of accumulators 2 and 3 stays legal.
- R10: A read and a write to the same accumulator in the same cycle return the value held before the write.
- R11: A write changes only the selected accumulator. The others keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Accumulator written |
| wr_view | input | 2 | Write view: 0 full, 1 long, 2 portion |
| wr_part | input | 2 | Write portion: 0 extension, 1 high, 2 low |
| wr_data | input | 36 | Write data, aligned to the low bits |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Accumulator read |
| rd_view | input | 2 | Read view: 0 full, 1 long, 2 portion |
| rd_part | input | 2 | Read portion: 0 extension, 1 high, 2 low |
| rd_data | output | 36 | Read result, combinational |
| rd_limit | output | 1 | Full-view read was limited |
| rd_illegal | output | 1 | Read address not permitted |
| wr_illegal | output | 1 | Write address not permitted, write dropped |

## Verification
The embedded properties check four things on every cycle:

- A dropped illegal write leaves the whole file unchanged.
- Accumulators that are not selected never move.
- A long-view write fills the guard bits from bit 31.
- A high-word portion write preserves the other two parts.

They also check that the limit flag appears only on full-view reads and only with one of the two limit constants.

The exact limited values, the zero-extension of portion reads and the word-move clearing of the low word are shown only by the scoreboard scenarios. The same holds for the old-value result of a same-cycle read and write, and for the illegal-read result.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [1:0] {
        VIEW_FULL = 2'd0,
        VIEW_LONG = 2'd1,
        VIEW_PART = 2'd2,
        VIEW_RSVD = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        PART_EXT  = 2'd0,
        PART_HI   = 2'd1,
        PART_LO   = 2'd2,
        PART_RSVD = 2'd3
    } part_e;

endpackage

// File: rtl/acc_access_check.sv
module acc_access_check
    import acc_pkg::*;
#(
    parameter int NUM_ACC       = 4,
    parameter int RESTRICT_FROM = 2,
    localparam int SEL_W        = $clog2(NUM_ACC)
) (
    input  logic [SEL_W-1:0] sel,
    input  view_e            view,
    input  part_e            part,
    output logic             illegal
);

    always_comb begin
        illegal = 1'b0;
        case (view)
            VIEW_RSVD: illegal = 1'b1;
            VIEW_PART: begin
                if (part == PART_RSVD) begin
                    illegal = 1'b1;
                end else if (part != PART_HI && 32'(sel) >= RESTRICT_FROM) begin
                    // only the high word of the upper accumulators is reachable
                    illegal = 1'b1;
                end
            end
            default: illegal = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_limiter.sv
module acc_limiter #(
    parameter int EXT_W  = 4,
    parameter int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
) (
    input  logic [ACC_W-1:0] acc_in,
    output logic [ACC_W-1:0] lim_out,
    output logic             over
);

    logic sign;

    always_comb begin
        sign    = acc_in[ACC_W-1];
        over    = acc_in[ACC_W-1:LONG_W] != {EXT_W{acc_in[LONG_W-1]}};
        lim_out = acc_in;
        if (over) begin
            if (sign) begin
                lim_out = {{(EXT_W + 1){1'b1}}, {(LONG_W - 1){1'b0}}};
            end else begin
                lim_out = {{(EXT_W + 1){1'b0}}, {(LONG_W - 1){1'b1}}};
            end
        end
    end

endmodule

// File: rtl/acc_write_merge.sv
module acc_write_merge
    import acc_pkg::*;
#(
    parameter int EXT_W  = 4,
    parameter int WORD_W = 16,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
) (
    input  logic [ACC_W-1:0] old_val,
    input  view_e            view,
    input  part_e            part,
    input  logic [ACC_W-1:0] data,
    output logic [ACC_W-1:0] new_val
);

    always_comb begin
        new_val = old_val;
        case (view)
            VIEW_FULL: begin
                if (part == PART_HI) begin
                    // word move: sign into guard bits, low word cleared
                    new_val = {{EXT_W{data[WORD_W-1]}}, data[WORD_W-1:0], {WORD_W{1'b0}}};
                end else begin
                    new_val = data;
                end
            end
            VIEW_LONG: new_val = {{EXT_W{data[LONG_W-1]}}, data[LONG_W-1:0]};
            VIEW_PART: begin
                case (part)
                    PART_EXT: new_val = {data[EXT_W-1:0], old_val[LONG_W-1:0]};
                    PART_HI:  new_val = {old_val[ACC_W-1:LONG_W], data[WORD_W-1:0], old_val[WORD_W-1:0]};
                    PART_LO:  new_val = {old_val[ACC_W-1:WORD_W], data[WORD_W-1:0]};
                    default:  new_val = old_val;
                endcase
            end
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/acc_file.sv
module acc_file
    import acc_pkg::*;
#(
    parameter int NUM_ACC       = 4,
    parameter int EXT_W         = 4,
    parameter int WORD_W        = 16,
    parameter int RESTRICT_FROM = 2,
    localparam int SEL_W  = $clog2(NUM_ACC),
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [1:0]       wr_view,
    input  logic [1:0]       wr_part,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [1:0]       rd_view,
    input  logic [1:0]       rd_part,
    output logic [ACC_W-1:0] rd_data,
    output logic             rd_limit,
    output logic             rd_illegal,
    output logic             wr_illegal
);

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    view_e wr_view_e, rd_view_e;
    part_e wr_part_e, rd_part_e;
    logic  wr_bad, rd_bad;
    logic  [ACC_W-1:0] wr_old, wr_new, rd_raw, rd_lim;
    logic  rd_over;

    assign wr_view_e = view_e'(wr_view);
    assign rd_view_e = view_e'(rd_view);
    assign wr_part_e = part_e'(wr_part);
    assign rd_part_e = part_e'(rd_part);

    acc_access_check #(.NUM_ACC(NUM_ACC), .RESTRICT_FROM(RESTRICT_FROM)) u_wr_chk (
        .sel(wr_sel), .view(wr_view_e), .part(wr_part_e), .illegal(wr_bad)
    );

    acc_access_check #(.NUM_ACC(NUM_ACC), .RESTRICT_FROM(RESTRICT_FROM)) u_rd_chk (
        .sel(rd_sel), .view(rd_view_e), .part(rd_part_e), .illegal(rd_bad)
    );

    assign wr_old = st_q.acc[wr_sel];
    assign rd_raw = st_q.acc[rd_sel];

    acc_write_merge #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_merge (
        .old_val(wr_old), .view(wr_view_e), .part(wr_part_e),
        .data(wr_data), .new_val(wr_new)
    );

    acc_limiter #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_lim (
        .acc_in(rd_raw), .lim_out(rd_lim), .over(rd_over)
    );

    // next-state process
    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_bad) begin
            st_d.acc[wr_sel] = wr_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read path: combinational from stored state, so same-cycle writes are not seen
    always_comb begin
        rd_data  = '0;
        rd_limit = 1'b0;
        if (rd_en && !rd_bad) begin
            case (rd_view_e)
                VIEW_FULL: begin
                    rd_data  = rd_lim;
                    rd_limit = rd_over;
                end
                VIEW_LONG: rd_data = {{EXT_W{rd_raw[LONG_W-1]}}, rd_raw[LONG_W-1:0]};
                VIEW_PART: begin
                    case (rd_part_e)
                        PART_EXT: rd_data = ACC_W'(rd_raw[ACC_W-1:LONG_W]);
                        PART_HI:  rd_data = ACC_W'(rd_raw[LONG_W-1:WORD_W]);
                        PART_LO:  rd_data = ACC_W'(rd_raw[WORD_W-1:0]);
                        default:  rd_data = '0;
                    endcase
                end
                default: rd_data = '0;
            endcase
        end
    end

    assign rd_illegal = rd_en && rd_bad;
    assign wr_illegal = wr_en && wr_bad;

    // ---------------- assertions ----------------
    assert_illegal_write_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(st_q));

    assert_long_guard_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_view_e == VIEW_LONG)
        |=> st_q.acc[$past(wr_sel)][ACC_W-1:LONG_W] == {EXT_W{$past(wr_data[LONG_W-1])}});

    assert_part_hi_keeps_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_view_e == VIEW_PART && wr_part_e == PART_HI)
        |=> (st_q.acc[$past(wr_sel)][ACC_W-1:LONG_W] == $past(wr_old[ACC_W-1:LONG_W]))
         && (st_q.acc[$past(wr_sel)][WORD_W-1:0] == $past(wr_old[WORD_W-1:0])));

    assert_limit_full_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_limit |-> (rd_en && rd_view_e == VIEW_FULL &&
                      (rd_data[LONG_W-1:0] == {1'b0, {(LONG_W - 1){1'b1}}} ||
                       rd_data[LONG_W-1:0] == {1'b1, {(LONG_W - 1){1'b0}}})));

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_hold
        assert_other_acc_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || wr_sel != SEL_W'(g)) |=> $stable(st_q.acc[g]));
    end

endmodule

// File: tb/tb_acc_file.sv
module tb_acc_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_sel = '0, wr_view = '0, wr_part = '0;
    logic [1:0]  rd_sel = '0, rd_view = '0, rd_part = '0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        rd_limit, rd_illegal, wr_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [35:0] data;
        logic        lim;
        logic        rill;
        logic        will;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [35:0] model [4];

    always #4 clk = ~clk;

    acc_file dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_view(wr_view), .wr_part(wr_part), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_view(rd_view), .rd_part(rd_part),
        .rd_data(rd_data), .rd_limit(rd_limit), .rd_illegal(rd_illegal), .wr_illegal(wr_illegal)
    );

    function automatic bit is_bad(logic [1:0] sel, logic [1:0] view, logic [1:0] part);
        if (view == 2'd3) return 1'b1;
        if (view == 2'd2 && (part == 2'd3 || (sel >= 2'd2 && part != 2'd1))) return 1'b1;
        return 1'b0;
    endfunction

    task automatic op(input bit we, input logic [1:0] ws, input logic [1:0] wv, input logic [1:0] wp,
                      input logic [35:0] wd, input bit re, input logic [1:0] rs, input logic [1:0] rv,
                      input logic [1:0] rp, input string tag);
        exp_t e;
        logic [35:0] cur;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_view = wv; wr_part = wp; wr_data = wd;
        rd_en = re; rd_sel = rs; rd_view = rv; rd_part = rp;
        e.data = '0; e.lim = 1'b0; e.tag = tag;
        e.rill = re && is_bad(rs, rv, rp);
        e.will = we && is_bad(ws, wv, wp);
        cur = model[rs];
        if (re && !e.rill) begin
            case (rv)
                2'd0: begin
                    if (cur[35:32] != {4{cur[31]}}) begin
                        e.lim  = 1'b1;
                        e.data = cur[35] ? 36'hF_8000_0000 : 36'h0_7FFF_FFFF;
                    end else e.data = cur;
                end
                2'd1: e.data = {{4{cur[31]}}, cur[31:0]};
                default: begin
                    if (rp == 2'd0) e.data = {32'h0, cur[35:32]};
                    else if (rp == 2'd1) e.data = {20'h0, cur[31:16]};
                    else e.data = {20'h0, cur[15:0]};
                end
            endcase
        end
        exp_q.push_back(e);
        if (we && !e.will) begin
            case (wv)
                2'd0: model[ws] = (wp == 2'd1) ? {{4{wd[15]}}, wd[15:0], 16'h0} : wd;
                2'd1: model[ws] = {{4{wd[31]}}, wd[31:0]};
                default: begin
                    if (wp == 2'd0) model[ws][35:32] = wd[3:0];
                    else if (wp == 2'd1) model[ws][31:16] = wd[15:0];
                    else model[ws][15:0] = wd[15:0];
                end
            endcase
        end
    endtask

    // monitor: sample 2 ns after the driver's falling-edge update
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (rd_data !== e.data || rd_limit !== e.lim || rd_illegal !== e.rill || wr_illegal !== e.will) begin
                failures++;
                $display("FAIL %s: got data=%h lim=%b rill=%b will=%b exp data=%h lim=%b rill=%b will=%b",
                         e.tag, rd_data, rd_limit, rd_illegal, wr_illegal, e.data, e.lim, e.rill, e.will);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 4; i++) op(0, 0, 0, 0, 0, 1, 2'(i), 1, 0, "R1 reset long read");
        // R2 full load and in-range read
        op(1, 0, 0, 0, 36'h0_1234_5678, 0, 0, 0, 0, "R2 load");
        op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R2 full read in range");
        // R3 positive overflow
        op(1, 1, 0, 2, 36'h1_0000_0000, 0, 0, 0, 0, "R2 load ovf");
        op(0, 0, 0, 0, 0, 1, 1, 0, 0, "R3 positive limit");
        op(0, 0, 0, 0, 0, 1, 1, 1, 0, "R4 long read no limit");
        op(0, 0, 0, 0, 0, 1, 1, 2, 0, "R6 portion ext read");
        // R3 negative overflow
        op(1, 1, 0, 0, 36'hE_0000_0001, 0, 0, 0, 0, "R2 load neg");
        op(0, 0, 0, 0, 0, 1, 1, 0, 0, "R3 negative limit");
        // R5 long write
        op(1, 2, 1, 0, 36'h0_8000_0003, 0, 0, 0, 0, "R5 long write");
        op(0, 0, 0, 0, 0, 1, 2, 0, 0, "R5 full read after long write");
        // R7 portion hi write on acc0
        op(1, 0, 2, 1, 36'h0_0000_BEEF, 0, 0, 0, 0, "R7 portion hi write");
        op(0, 0, 0, 0, 0, 1, 0, 2, 2, "R7 low kept");
        op(0, 0, 0, 0, 0, 1, 0, 2, 0, "R7 ext kept");
        op(0, 0, 0, 0, 0, 1, 0, 1, 0, "R4 long read sign");
        op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3 limit after portion write");
        op(1, 0, 2, 0, 36'h0_0000_000F, 0, 0, 0, 0, "R7 portion ext write");
        op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R2 restored full read");
        // R8 word move
        op(1, 3, 1, 0, 36'h0_0000_1234, 0, 0, 0, 0, "R5 preload acc3");
        op(1, 3, 0, 1, 36'h0_0000_8001, 0, 0, 0, 0, "R8 word move");
        op(0, 0, 0, 0, 0, 1, 3, 0, 0, "R8 full read");
        op(1, 3, 0, 1, 36'h0_0000_0042, 1, 3, 1, 0, "R8 pos word move");
        op(0, 0, 0, 0, 0, 1, 3, 1, 0, "R8 read pos");
        // R9 illegal accesses
        op(1, 2, 2, 2, 36'h0_0000_5555, 0, 0, 0, 0, "R9 illegal write lo acc2");
        op(0, 0, 0, 0, 0, 1, 2, 0, 0, "R9 acc2 unchanged");
        op(1, 3, 2, 0, 36'h0_0000_0007, 1, 3, 2, 0, "R9 illegal ext both ports");
        op(1, 1, 3, 0, 36'h0_0000_0000, 1, 1, 3, 0, "R9 reserved view");
        op(0, 0, 0, 0, 0, 1, 1, 0, 0, "R9 acc1 unchanged");
        op(1, 2, 2, 1, 36'h0_0000_7777, 1, 2, 2, 1, "R9 hi portion of acc2 legal");
        op(0, 0, 0, 0, 0, 1, 2, 2, 1, "R9 acc2 hi written");
        op(0, 0, 0, 0, 0, 1, 0, 2, 3, "R9 portion code 3 read");
        // R10 same-cycle read/write
        op(1, 0, 0, 0, 36'h0_0000_0001, 1, 0, 0, 0, "R10 read old value");
        op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 new value visible");
        // R11 others untouched
        op(0, 0, 0, 0, 0, 1, 1, 2, 0, "R11 acc1 ext");
        op(0, 0, 0, 0, 0, 1, 2, 1, 0, "R11 acc2 long");
        op(0, 0, 0, 0, 0, 1, 3, 2, 1, "R11 acc3 hi");
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule